// File: doc/BRIEF.md
# Radix-4 Mux-Select Pipelined Multiplier

This block multiplies two signed N-bit operands and returns the exact 2N-bit product a fixed number of clock cycles later. The multiplier operand is cut into 2-bit digits. Each digit drives a small four-way selector that picks a multiple of the multiplicand. The partial products are then summed in a binary tree of plain two-input adders, with a register after every tree level. The triple of the multiplicand is built once, in the first pipeline stage, and every digit selector shares it. Only the most significant digit is read as signed, so no recoding logic is needed.

A new operand pair may be presented on every clock cycle together with a valid strobe. The strobe travels alongside the data and marks the cycle in which the matching product appears. The operand width N must be even and at least 2.

Top module: `mul_r4_top`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the exact signed product of the operand pair that was accepted with the matching `in_valid`, over the full 2N bits.
- R2: The pipeline depth is LAT = 2 + ceil(log2(N/2)) register stages (4 for N = 8). A pair captured on rising edge t appears right after rising edge t+LAT-1. `out_valid` is `in_valid` delayed by the same number of edges.
- R3: A pair is accepted on every cycle in which `in_valid` is high, including back-to-back cycles. Each result depends only on its own pair.
- R4: For every digit below the top one, the digit is bit pair [2i+1:2i] of `in_b` and has weight 4^i. Its codes 00, 01, 10 and 11 add 0, 1, 2 and 3 times `in_a`.
- R5: The top digit is bits [N-1:N-2] of `in_b` and has weight 4^(N/2-1). Its codes 00, 01, 10 and 11 add 0, +1, -2 and -1 times `in_a`.
- R6: The extreme operands give exact results with no overflow: (-2^(N-1))·(-2^(N-1)), (-2^(N-1))·(-1), (-2^(N-1))·0, (-2^(N-1))·1 and (2^(N-1)-1)·(2^(N-1)-1).
- R7: A synchronous active-high `rst` empties the valid pipeline. `out_valid` is low after every edge at which `rst` is high, and `in_valid` is ignored at those edges. After release, only pairs accepted after reset produce `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline only |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_a | input | N | Signed multiplicand |
| in_b | input | N | Signed multiplier, cut into 2-bit digits |
| out_valid | output | 1 | `out_product` holds a result |
| out_product | output | 2N | Signed product |

## Verification
Several properties are checked on every clock. The checker compares the valid strobe and each product against its own delayed copies of the inputs. It confirms that the shared triple term is three times the captured multiplicand. It checks that the top-digit partial product carries the sign expected from the multiplicand's sign and the top digit's negative codes. It also checks that `out_valid` falls after any reset edge. Other behaviour shows only through the bench's scenarios: each digit code in each position, the extreme operand pairs, gaps and back-to-back streams, and a reset that arrives while the pipe is full.

// File: rtl/mul_r4_pkg.sv
package mul_r4_pkg;

  // Which multiple of the multiplicand a digit selects.
  typedef enum logic [2:0] {
    MSEL_ZERO,
    MSEL_POS1,
    MSEL_POS2,
    MSEL_POS3,
    MSEL_NEG2,
    MSEL_NEG1
  } mult_sel_e;

  // Lower digits are unsigned (0..3); the top digit is signed (0,+1,-2,-1).
  function automatic mult_sel_e decode_digit(input logic [1:0] code, input logic is_top);
    mult_sel_e sel;
    case (code)
      2'b00:   sel = MSEL_ZERO;
      2'b01:   sel = MSEL_POS1;
      2'b10:   sel = is_top ? MSEL_NEG2 : MSEL_POS2;
      default: sel = is_top ? MSEL_NEG1 : MSEL_POS3;
    endcase
    return sel;
  endfunction

  // Number of registered adder levels for a given digit count.
  function automatic int unsigned tree_levels(input int unsigned digits);
    return (digits <= 1) ? 0 : $clog2(digits);
  endfunction

  // Triple stage + adder levels + output register.
  function automatic int unsigned pipe_latency(input int unsigned width);
    return 2 + tree_levels(width / 2);
  endfunction

  // Node index where tree level k begins (level 0 = leaves).
  function automatic int unsigned level_offset(input int unsigned leaves, input int unsigned k);
    return 2 * leaves - 2 * (leaves >> k);
  endfunction

endpackage

// File: rtl/mul_r4_x3_stage.sv
module mul_r4_x3_stage #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic [N-1:0] a_q,
  output logic [N+1:0] a3_q,
  output logic [N-1:0] b_q
);

  // Three times the multiplicand, built as A + 2A, sign-extended to N+2 bits.
  function automatic logic [N+1:0] triple(input logic [N-1:0] a);
    logic [N+1:0] one_x;
    logic [N+1:0] two_x;
    one_x = {a[N-1], a[N-1], a};
    two_x = {a[N-1], a, 1'b0};
    return one_x + two_x;
  endfunction

  // Data registers carry no reset.
  always_ff @(posedge clk) begin
    a_q  <= in_a;
    a3_q <= triple(in_a);
    b_q  <= in_b;
  end

endmodule

// File: rtl/mul_r4_digit_mux.sv
module mul_r4_digit_mux
  import mul_r4_pkg::*;
#(
  parameter int N      = 8,
  parameter int W      = 2 * N,
  parameter int LEAVES = 4
) (
  input  logic [N-1:0]        a_q,
  input  logic [N+1:0]        a3_q,
  input  logic [N-1:0]        b_q,
  output logic [LEAVES*W-1:0] leaves
);

  localparam int DIGITS = N / 2;

  logic signed [N-1:0] a_s;
  logic signed [N+1:0] a3_s;
  logic [W-1:0]        a_w;
  logic [W-1:0]        a3_w;

  assign a_s  = a_q;
  assign a3_s = a3_q;
  assign a_w  = W'(a_s);
  assign a3_w = W'(a3_s);

  // Negative multiples are formed at full result width, so -2A never overflows.
  function automatic logic [W-1:0] pick(input mult_sel_e sel,
                                        input logic [W-1:0] one_x,
                                        input logic [W-1:0] three_x);
    logic [W-1:0] r;
    case (sel)
      MSEL_POS1: r = one_x;
      MSEL_POS2: r = one_x << 1;
      MSEL_POS3: r = three_x;
      MSEL_NEG2: r = '0 - (one_x << 1);
      MSEL_NEG1: r = '0 - one_x;
      default:   r = '0;
    endcase
    return r;
  endfunction

  for (genvar d = 0; d < LEAVES; d++) begin : g_digit
    if (d < DIGITS) begin : g_used
      mult_sel_e sel;
      assign sel = decode_digit(b_q[2*d +: 2], (d == DIGITS - 1));
      // Alignment by 2*d is wiring only.
      assign leaves[d*W +: W] = pick(sel, a_w, a3_w) << (2 * d);
    end else begin : g_pad
      assign leaves[d*W +: W] = '0;
    end
  end

endmodule

// File: rtl/mul_r4_add_level.sv
module mul_r4_add_level #(
  parameter int W         = 16,
  parameter int COUNT_OUT = 2
) (
  input  logic                     clk,
  input  logic [2*COUNT_OUT*W-1:0] in_bus,
  output logic [COUNT_OUT*W-1:0]   out_bus
);

  for (genvar j = 0; j < COUNT_OUT; j++) begin : g_node
    always_ff @(posedge clk) begin
      out_bus[j*W +: W] <= in_bus[(2*j)*W +: W] + in_bus[(2*j+1)*W +: W];
    end
  end

endmodule

// File: rtl/mul_r4_top.sv
module mul_r4_top
  import mul_r4_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [N-1:0]   in_a,
  input  logic signed [N-1:0]   in_b,
  output logic                  out_valid,
  output logic signed [2*N-1:0] out_product
);

  localparam int W      = 2 * N;
  localparam int DIGITS = N / 2;
  localparam int LEVELS = int'(tree_levels(DIGITS));
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int LAT    = int'(pipe_latency(N));

  // Named internal wires, also observed by the bound checker.
  logic [N-1:0]       a_q;
  logic [N+1:0]       a3_q;
  logic [N-1:0]       b_q;
  logic [W-1:0]       top_leaf;
  logic [NODES*W-1:0] tree_bus;
  logic [LAT-1:0]     vpipe;

  mul_r4_x3_stage #(.N(N)) x3_i (
    .clk  (clk),
    .in_a (in_a),
    .in_b (in_b),
    .a_q  (a_q),
    .a3_q (a3_q),
    .b_q  (b_q)
  );

  mul_r4_digit_mux #(.N(N), .W(W), .LEAVES(LEAVES)) mux_i (
    .a_q    (a_q),
    .a3_q   (a3_q),
    .b_q    (b_q),
    .leaves (tree_bus[0 +: LEAVES*W])
  );

  assign top_leaf = tree_bus[(DIGITS-1)*W +: W];

  for (genvar k = 0; k < LEVELS; k++) begin : g_level
    localparam int OFF_IN  = int'(level_offset(LEAVES, k));
    localparam int OFF_OUT = int'(level_offset(LEAVES, k + 1));
    localparam int CNT_OUT = LEAVES >> (k + 1);
    mul_r4_add_level #(.W(W), .COUNT_OUT(CNT_OUT)) lvl_i (
      .clk     (clk),
      .in_bus  (tree_bus[OFF_IN*W +: 2*CNT_OUT*W]),
      .out_bus (tree_bus[OFF_OUT*W +: CNT_OUT*W])
    );
  end

  always_ff @(posedge clk) begin
    out_product <= tree_bus[(NODES-1)*W +: W];
  end

  // Valid pipeline, the only state cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];

endmodule

// File: rtl/mul_r4_chk.sv
module mul_r4_chk
  import mul_r4_pkg::*;
#(
  parameter int N = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic signed [N-1:0]   in_a,
  input logic signed [N-1:0]   in_b,
  input logic                  out_valid,
  input logic signed [2*N-1:0] out_product,
  input logic [N-1:0]          a_q,
  input logic [N+1:0]          a3_q,
  input logic [N-1:0]          b_q,
  input logic [2*N-1:0]        top_leaf
);

  localparam int W   = 2 * N;
  localparam int LAT = int'(pipe_latency(N));

  logic [W-1:0]   prod_ref;
  logic [N+1:0]   a3_ref;
  logic [LAT-1:0] vsh;
  logic [W-1:0]   psh [LAT];

  assign prod_ref = W'(W'(in_a) * W'(in_b));
  assign a3_ref   = (N+2)'(3 * in_a);

  always_ff @(posedge clk) begin
    if (rst) vsh <= '0;
    else     vsh <= {vsh[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    psh[0] <= prod_ref;
    for (int i = 1; i < LAT; i++) psh[i] <= psh[i-1];
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_product == psh[LAT-1]));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[LAT-1]);

  assert_triple_term_R4: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) |-> (a3_q == $past(a3_ref)));

  assert_top_digit_sign_R5: assert property (@(posedge clk) disable iff (rst)
    ((b_q[N-1:N-2] != 2'b00) && (a_q != '0)) |-> (top_leaf[W-1] == (a_q[N-1] ^ b_q[N-1])));

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind mul_r4_top mul_r4_chk #(.N(N)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_product (out_product),
  .a_q         (a_q),
  .a3_q        (a3_q),
  .b_q         (b_q),
  .top_leaf    (top_leaf)
);

// File: tb/mul_r4_top_tb_top.sv
`timescale 1ns/1ps
module mul_r4_top_tb_top;

  localparam int N   = 8;
  localparam int W   = 2 * N;
  localparam int LAT = 2 + $clog2(N / 2);   // R2 formula
  localparam logic signed [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic signed [N-1:0] MOST_POS = {1'b0, {(N-1){1'b1}}};

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  in_valid = 1'b0;
  logic signed [N-1:0]   in_a = '0;
  logic signed [N-1:0]   in_b = '0;
  logic                  out_valid;
  logic signed [W-1:0]   out_product;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R7";
  bit    finished = 1'b0;

  typedef struct {
    bit     v;
    longint p;
    string  tag;
  } exp_t;

  exp_t q[$];
  exp_t cur_exp;

  always #4 clk = ~clk;   // 125 MHz

  mul_r4_top #(.N(N)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Reference model: a queue of captured pairs, one entry per clock.
  always @(posedge clk) begin
    exp_t e;
    e.v   = in_valid;
    e.p   = longint'(in_a) * longint'(in_b);
    e.tag = cur_tag;
    if (rst) begin
      exp_t z;
      z.v = 1'b0; z.p = 0; z.tag = "R7";
      q.delete();
      for (int i = 0; i < LAT - 1; i++) q.push_back(z);
      cur_exp = z;
    end else begin
      q.push_back(e);
      cur_exp = q.pop_front();
    end
    #2;
    if (cur_exp.v) begin
      check(out_valid == 1'b1, {cur_exp.tag, "/R2"}, "out_valid", out_valid, 1);
      check(longint'(out_product) == cur_exp.p, {cur_exp.tag, "/R1"}, "out_product",
            longint'(out_product), cur_exp.p);
    end else begin
      check(out_valid == 1'b0, {cur_exp.tag, "/R2"}, "out_valid", out_valid, 0);
    end
  end

  task automatic send(input logic signed [N-1:0] a, input logic signed [N-1:0] b,
                      input string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1; cur_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_a = N'($urandom); in_b = N'($urandom); cur_tag = tag;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    // R7: in_valid held high during reset must be ignored.
    in_valid = 1'b1; in_a = 8'sd5; in_b = 8'sd7;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    rst = 1'b0;

    // R6 corner pairs.
    send(MOST_NEG, MOST_NEG, "R6");
    send(MOST_NEG, -8'sd1, "R6");
    send(MOST_NEG, 8'sd0, "R6");
    send(MOST_NEG, 8'sd1, "R6");
    send(MOST_POS, MOST_POS, "R6");
    send(-8'sd1, MOST_NEG, "R6");
    send(MOST_POS, MOST_NEG, "R6");

    // R4: lower digits across codes 01, 10, 11 (top digit 00).
    send(8'sd37, 8'sd63, "R4");
    send(-8'sd37, 8'sd63, "R4");
    send(8'sd91, 8'sd21, "R4");
    send(-8'sd91, 8'sd42, "R4");
    send(MOST_NEG, 8'sd3, "R4");
    send(MOST_NEG, 8'sd12, "R4");

    // R5: top digit codes 01, 10, 11.
    send(8'sd25, 8'sd64, "R5");
    send(8'sd25, MOST_NEG, "R5");
    send(-8'sd25, -8'sd64, "R5");
    send(MOST_NEG, -8'sd64, "R5");
    send(MOST_POS, -8'sd1, "R5");
    send(MOST_NEG, -8'sd2, "R5");

    // R2: isolated pulses separated by gaps.
    idle(3, "R2");
    send(8'sd11, -8'sd13, "R2");
    idle(LAT + 1, "R2");
    send(-8'sd9, 8'sd9, "R2");
    idle(2, "R2");

    // R3: back-to-back random stream with occasional gaps.
    for (int i = 0; i < 300; i++) begin
      if ((i % 17) == 5) idle(1, "R3");
      else send(N'($urandom), N'($urandom), "R3");
    end

    // R7: reset while the pipe is full, then restart.
    send(8'sd100, 8'sd3, "R7");
    send(8'sd50, 8'sd3, "R7");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after mid-stream reset", out_valid, 0);
    rst = 1'b0;
    idle(LAT, "R7");
    send(-8'sd77, 8'sd66, "R1");
    send(MOST_NEG, MOST_NEG, "R6");
    idle(LAT + 2, "R2");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule